// File: doc/BRIEF.md
# Indirect Redirection-Table Register Port

This block is the register front end of an interrupt redirection controller. Software does not see a flat map of registers. It sees two words. The first is a select word, which holds an 8-bit register index. The second is a data window, which reads or writes whichever register the index names. Each table entry is 64 bits wide and is reached through two consecutive indices: an even one for the low word and an odd one for the high word.

A write through the window to a table word stores that word. On the next cycle the block also publishes the complete new 64-bit entry, together with its pin number, on an update port that the dispatch logic consumes. Read data is combinational. It depends on the bus offset and on the register state as it stands after the last clock edge. Interrupt sampling and delivery belong to the neighbouring logic.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the select word is 0, the controller ID is 0, and every table entry holds 64'h0000_0000_0001_0000, which means only the mask bit (bit 16) is set.
- R2: Only bus_addr[7:0] is decoded. Offset 8'h00 is the select word and offset 8'h10 is the window. Any other offset reads as zero and ignores writes. Address bits above bit 7 do not affect the decode.
- R3: A write at offset 8'h00 loads bus_wdata[7:0] into the select word. A read at 8'h00 returns {24'h0, select}. All read data is combinational and valid in the same cycle as the address.
- R4: Index 0 is the controller ID. A window write stores bus_wdata[27:24]. A window read returns the ID in bits 27:24 and zero in every other bit.
- R5: Index 1 is a read-only version word with the value {8'h00, NUM_PINS-1, 8'h00, 8'h11}. That is 32'h0017_0011 for the default of 24 pins. Window writes to index 1 change nothing.
- R6: Index 8'h10+2n is bits 31:0 of entry n and index 8'h11+2n is bits 63:32 of entry n, for n from 0 to NUM_PINS-1. Window reads return the stored word.
- R7: A write to one word of an entry leaves the other 32 bits of that entry unchanged.
- R8: Window writes to indices at or above 8'h10+2*NUM_PINS, and to indices 2 through 8'h0F, change no state and publish no update. Window reads of those indices return zero.
- R9: In the cycle after a window write to a valid table index, upd_valid is 1, upd_pin is the entry number and upd_entry is the complete new 64-bit entry. In every other cycle upd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address within the 4 KB region |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| upd_valid | output | 1 | One-cycle pulse after a table write |
| upd_pin | output | PIN_W (5) | Entry number that was written |
| upd_entry | output | 64 | Complete entry value after the write |

## Verification
Two activities can share a cycle. The update port publishes the entry from the previous table write while the bus is already writing the same word again. The bench provokes this with back-to-back window writes to the same index. It then checks that the first publication carries only the first value, that the next one carries the second value, and that the untouched half appears unchanged in both. Reads that follow a select change are checked in the same way. They must show the newly indexed register in the cycle after the select write.

// File: rtl/irq_route_pkg.sv
// Package: shared offsets, index codes and reset values for the
// redirection-table register port. Assumes an 8-bit index space.
package irq_route_pkg;
    localparam logic [7:0]  OFS_SELECT  = 8'h00;
    localparam logic [7:0]  OFS_WINDOW  = 8'h10;
    localparam logic [7:0]  IDX_CTRL_ID = 8'h00;
    localparam logic [7:0]  IDX_VERSION = 8'h01;
    localparam logic [7:0]  IDX_TABLE0  = 8'h10;
    localparam logic [7:0]  VERSION_ID  = 8'h11;
    localparam logic [63:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        REG_CTRL_ID,
        REG_VERSION,
        REG_TBL_LO,
        REG_TBL_HI,
        REG_NONE
    } reg_kind_e;
endpackage

// File: rtl/irq_route_decode.sv
// Index decoder: classifies the 8-bit select value into a register kind
// and a table entry number. Assumes NUM_PINS <= 120 so that all table
// indices fit below 256.
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [7:0]       sel,
    output reg_kind_e        kind,
    output logic [PIN_W-1:0] pin
);
    logic [7:0] tbl_off;
    logic       in_table;

    assign tbl_off  = sel - IDX_TABLE0;
    assign in_table = (sel >= IDX_TABLE0) && (tbl_off[7:1] < 7'(NUM_PINS));
    assign pin      = tbl_off[PIN_W:1];

    // Purpose: map the select value to the register it names.
    always_comb begin
        if (sel == IDX_CTRL_ID)      kind = REG_CTRL_ID;
        else if (sel == IDX_VERSION) kind = REG_VERSION;
        else if (in_table)           kind = tbl_off[0] ? REG_TBL_HI : REG_TBL_LO;
        else                         kind = REG_NONE;
    end
endmodule

// File: rtl/irq_route_slot.sv
// One 64-bit redirection entry. Loads the pre-merged value when selected.
// Resets to the masked state.
module irq_route_slot
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [63:0] next_val,
    output logic [63:0] val
);
    // Purpose: hold the entry, masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    val <= ENTRY_RESET;
        else if (load) val <= next_val;
    end
endmodule

// File: rtl/irq_route_table.sv
// Entry table: NUM_PINS slots with a single 32-bit half-word write port,
// a combinational read port and a registered update publication.
// Assumes wr_pin < NUM_PINS whenever wr_en is high.
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic [PIN_W-1:0] wr_pin,
    input  logic [31:0]      wr_data,
    input  logic [PIN_W-1:0] rd_pin,
    output logic [63:0]      rd_entry,
    output logic             upd_valid,
    output logic [PIN_W-1:0] upd_pin,
    output logic [63:0]      upd_entry
);
    logic [63:0] slot_q [NUM_PINS];
    logic [63:0] old_val;
    logic [63:0] merged;

    assign old_val  = slot_q[wr_pin];
    assign merged   = wr_hi ? {wr_data, old_val[31:0]} : {old_val[63:32], wr_data};
    assign rd_entry = slot_q[rd_pin];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_slot
        irq_route_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wr_en && (wr_pin == PIN_W'(g))),
            .next_val (merged),
            .val      (slot_q[g])
        );
    end

    // Purpose: publish the freshly written entry one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_pin   <= '0;
            upd_entry <= '0;
        end else begin
            upd_valid <= wr_en;
            if (wr_en) begin
                upd_pin   <= wr_pin;
                upd_entry <= merged;
            end
        end
    end
endmodule

// File: rtl/irq_route_regs.sv
// Top: select word and data window over the controller ID, the version
// word and the entry table. Decodes bus_addr[7:0] only. Read data is
// combinational from the address and the current state.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int ADDR_W   = 12,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              upd_valid,
    output logic [PIN_W-1:0]  upd_pin,
    output logic [63:0]       upd_entry
);
    localparam logic [31:0] VERSION_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_ID};

    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    logic [7:0]       offset;
    logic             hit_sel;
    logic             hit_win;
    reg_kind_e        kind;
    logic [PIN_W-1:0] pin;
    logic [63:0]      rd_entry;
    logic             tbl_wr;
    logic             unused_addr_hi;

    assign offset         = bus_addr[7:0];
    assign unused_addr_hi = ^bus_addr[ADDR_W-1:8];
    assign hit_sel        = (offset == OFS_SELECT);
    assign hit_win        = (offset == OFS_WINDOW);
    assign tbl_wr         = bus_we && hit_win && (kind == REG_TBL_LO || kind == REG_TBL_HI);

    irq_route_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .sel  (sel_q),
        .kind (kind),
        .pin  (pin)
    );

    irq_route_table #(.NUM_PINS(NUM_PINS)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_wr),
        .wr_hi     (kind == REG_TBL_HI),
        .wr_pin    (pin),
        .wr_data   (bus_wdata),
        .rd_pin    (pin),
        .rd_entry  (rd_entry),
        .upd_valid (upd_valid),
        .upd_pin   (upd_pin),
        .upd_entry (upd_entry)
    );

    // Purpose: select word loads from the low data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sel_q <= '0;
        else if (bus_we && hit_sel) sel_q <= bus_wdata[7:0];
    end

    // Purpose: controller ID loads from data bits 27:24 through the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        id_q <= '0;
        else if (bus_we && hit_win && kind == REG_CTRL_ID) id_q <= bus_wdata[27:24];
    end

    // Purpose: combinational read mux for the two bus offsets.
    always_comb begin
        bus_rdata = '0;
        if (hit_sel) begin
            bus_rdata = {24'h0, sel_q};
        end else if (hit_win) begin
            case (kind)
                REG_CTRL_ID: bus_rdata = {4'h0, id_q, 24'h0};
                REG_VERSION: bus_rdata = VERSION_WORD;
                REG_TBL_LO:  bus_rdata = rd_entry[31:0];
                REG_TBL_HI:  bus_rdata = rd_entry[63:32];
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// Checker: temporal properties of the register port, bound to the top.
module irq_route_regs_chk #(
    parameter int NUM_PINS = 24,
    parameter int ADDR_W   = 12,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              upd_valid,
    input logic [PIN_W-1:0]  upd_pin,
    input logic [63:0]       upd_entry,
    input logic [7:0]        sel_q,
    input logic [3:0]        id_q
);
    logic win_c, sel_c, tbl_ok, tbl_beyond;
    assign win_c      = bus_addr[7:0] == 8'h10;
    assign sel_c      = bus_addr[7:0] == 8'h00;
    assign tbl_ok     = (int'(sel_q) >= 16) && (int'(sel_q) < 16 + 2 * NUM_PINS);
    assign tbl_beyond = int'(sel_q) >= 16 + 2 * NUM_PINS;

    // R3
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_c) |=> (sel_q == $past(bus_wdata[7:0])));

    // R4
    id_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(id_q) |-> $past(bus_we && win_c && sel_q == 8'h00));

    // R9
    upd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(bus_we && win_c && tbl_ok));

    // R8
    upd_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && win_c && tbl_beyond) |=> !upd_valid);

    // R7
    upd_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && win_c && tbl_ok && !sel_q[0]) |=>
            (upd_entry[31:0] == $past(bus_wdata) && upd_pin == PIN_W'(($past(sel_q) - 8'h10) >> 1)));

    // R5
    ver_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_c && sel_q == 8'h01) |-> (bus_rdata[7:0] == 8'h11 && bus_rdata[31:24] == 8'h00));
endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .upd_valid (upd_valid),
    .upd_pin   (upd_pin),
    .upd_entry (upd_entry),
    .sel_q     (sel_q),
    .id_q      (id_q)
);

// File: tb/irq_route_regs_test.sv
// Scoreboard bench: the driver pushes expectations tagged with the cycle
// they belong to; the monitor pops and compares them mid-cycle.
module irq_route_regs_test;
    localparam int NP = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        upd_valid;
    logic [4:0]  upd_pin;
    logic [63:0] upd_entry;

    always #4 clk = ~clk;

    irq_route_regs #(.NUM_PINS(NP), .ADDR_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .upd_valid(upd_valid),
        .upd_pin(upd_pin), .upd_entry(upd_entry)
    );

    typedef struct {
        int          cyc;
        int          kind;   // 0 read, 1 update, 2 no update
        logic [63:0] exp;
        int          pin;
        string       req;
    } item_t;

    item_t q[$];
    int drv_cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        drv_cyc++;
        bus_we = we; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, a, d);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string r);
        item_t it;
        step(1'b0, a, '0);
        it.cyc = drv_cyc; it.kind = 0; it.exp = {32'h0, e}; it.pin = 0; it.req = r;
        q.push_back(it);
    endtask

    task automatic exp_upd(input int p, input logic [63:0] e, input string r);
        item_t it;
        it.cyc = drv_cyc + 1; it.kind = 1; it.exp = e; it.pin = p; it.req = r;
        q.push_back(it);
    endtask

    task automatic exp_noupd(input string r);
        item_t it;
        it.cyc = drv_cyc + 1; it.kind = 2; it.exp = '0; it.pin = 0; it.req = r;
        q.push_back(it);
    endtask

    // Monitor: compare every expectation due in the current cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0 && q[0].cyc <= drv_cyc) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (it.kind == 0 && bus_rdata !== it.exp[31:0]) begin
                    n_bad++;
                    $display("FAIL %s: rdata actual %h expected %h", it.req, bus_rdata, it.exp[31:0]);
                end else if (it.kind == 1 && (upd_valid !== 1'b1 || upd_pin !== 5'(it.pin) || upd_entry !== it.exp)) begin
                    n_bad++;
                    $display("FAIL %s: update actual v=%b pin=%0d %h expected v=1 pin=%0d %h",
                             it.req, upd_valid, upd_pin, upd_entry, it.pin, it.exp);
                end else if (it.kind == 2 && upd_valid !== 1'b0) begin
                    n_bad++;
                    $display("FAIL %s: upd_valid actual %b expected 0", it.req, upd_valid);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step(1'b0, '0, '0);
        rst_n = 1'b1;
        // R1 reset state
        rd(12'h000, 32'h0, "R1");
        rd(12'h010, 32'h0, "R1");
        wr(12'h000, 32'h10);
        rd(12'h010, 32'h0001_0000, "R1");
        wr(12'h000, 32'h11);
        rd(12'h010, 32'h0, "R1");
        // R3 select takes the low byte
        wr(12'h000, 32'hABCD_EF01);
        rd(12'h000, 32'h01, "R3");
        rd(12'h010, 32'h0017_0011, "R5");
        // R4 controller ID
        wr(12'h000, 32'h0);
        wr(12'h010, 32'hFFFF_FFFF);
        exp_noupd("R9");
        rd(12'h010, 32'h0F00_0000, "R4");
        wr(12'h010, 32'h0500_0000);
        rd(12'h010, 32'h0500_0000, "R4");
        // R5 version is read-only
        wr(12'h000, 32'h1);
        wr(12'h010, 32'h0);
        exp_noupd("R5");
        rd(12'h010, 32'h0017_0011, "R5");
        // R8 undefined low indices
        wr(12'h000, 32'h2);
        rd(12'h010, 32'h0, "R8");
        wr(12'h000, 32'h0F);
        rd(12'h010, 32'h0, "R8");
        // R6 R7 R9 entry 0 halves
        wr(12'h000, 32'h10);
        wr(12'h010, 32'h0000_09A5);
        exp_upd(0, 64'h0000_0000_0000_09A5, "R9");
        rd(12'h010, 32'h0000_09A5, "R6");
        exp_noupd("R9");
        wr(12'h000, 32'h11);
        rd(12'h010, 32'h0, "R7");
        wr(12'h010, 32'hDEAD_BEEF);
        exp_upd(0, 64'hDEAD_BEEF_0000_09A5, "R7");
        // back-to-back writes to the same word overlap with publication
        wr(12'h010, 32'hCAFE_F00D);
        exp_upd(0, 64'hCAFE_F00D_0000_09A5, "R9");
        rd(12'h010, 32'hCAFE_F00D, "R6");
        wr(12'h000, 32'h10);
        rd(12'h010, 32'h0000_09A5, "R7");
        // R6 last entry
        wr(12'h000, 32'h3E);
        wr(12'h010, 32'h1111_2222);
        exp_upd(NP - 1, 64'h0000_0000_1111_2222, "R6");
        wr(12'h000, 32'h3F);
        wr(12'h010, 32'h3333_4444);
        exp_upd(NP - 1, 64'h3333_4444_1111_2222, "R7");
        rd(12'h010, 32'h3333_4444, "R6");
        // R8 beyond the last entry
        wr(12'h000, 32'h40);
        wr(12'h010, 32'h1234);
        exp_noupd("R8");
        rd(12'h010, 32'h0, "R8");
        wr(12'h000, 32'hFF);
        wr(12'h010, 32'h5678);
        exp_noupd("R8");
        rd(12'h010, 32'h0, "R8");
        wr(12'h000, 32'h3F);
        rd(12'h010, 32'h3333_4444, "R8");
        // R2 decode of the low address byte only
        wr(12'h100, 32'h12);
        rd(12'h000, 32'h12, "R2");
        rd(12'h110, 32'h0001_0000, "R2");
        wr(12'h004, 32'h55);
        rd(12'h000, 32'h12, "R2");
        rd(12'h004, 32'h0, "R2");
        wr(12'h014, 32'h77);
        exp_noupd("R2");
        rd(12'h010, 32'h0001_0000, "R2");
        repeat (4) step(1'b0, '0, '0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule